// File: doc/BRIEF.md
# Sleep Mode and Module-Stop Controller

This block holds a processor core in a low-power sleep state and wakes it again. A sleep strobe from the core halts it unless the standby-select input asks for the deeper standby path, which this block does not enter. Register contents in the core are left alone: the block only raises a halt. Peripherals keep their clocks, and the clock output stays enabled. Two status pins report the state.

Any of four interrupt classes ends sleep. These are non-maskable, external, encoded-level and peripheral. The block-interrupt flag is ignored while asleep. On acceptance the block pulses an accept strobe and latches the winning source's 12-bit event code into two registers. A writable module-stop register drives glitch-free clock gates for two serial ports. A manual reset returns the block to run and clears the module-stop register.

Top module: `slp_ctrl_top`

## Requirements
- R1: A sleep_i pulse with stby_sel_i=0 in run state sets cpu_halt_o at the next rising edge, and the halt stays high until a wake.
- R2: A sleep_i pulse with stby_sel_i=1 leaves the block in run with cpu_halt_o low.
- R3: status_o is 2'b10 in sleep and 2'b00 in run. clk_out_en_o is 1 in both states.
- R4: In sleep, any request wakes the core at the next edge. A request is nmi_i, irq_req_i, a nonzero irl_i or per_req_i. The wake returns the block to run and raises int_accept_o for one cycle.
- R5: In sleep a request is accepted whatever bl_i is. In run it is accepted only with bl_i=0, and with bl_i=1 there is neither a strobe nor a code change.
- R6: On acceptance both evt_code_o and evt_code2_o take the code of the highest-priority pending class. The order is nmi (code NMI_CODE, default 12'h1C0), then irq (irq_code_i), then irl (12'h200 + 32*irl_i), then peripheral (per_code_i). Without acceptance both registers hold.
- R7: mstp_rdata_o reads back the 32-bit register written through mstp_we_i/mstp_wdata_i at the next edge. The register resets to 0.
- R8: Bit 31 set stops sp_clk_o[1] and bit 30 set stops sp_clk_o[0], each independently and in both states. Each gate enable changes on the falling clock edge only.
- R9: man_rst_i at an edge returns the block to run, clears the module-stop register and gives no accept strobe. The event codes keep their values.
- R10: If a request is accepted in the same cycle as a sleep strobe, the accept wins and the block stays in run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | clock |
| rst_ni | input | 1 | asynchronous power-on reset, active low |
| man_rst_i | input | 1 | synchronous manual reset |
| sleep_i | input | 1 | sleep instruction strobe |
| stby_sel_i | input | 1 | standby select, 0 for sleep |
| bl_i | input | 1 | block-interrupt flag |
| nmi_i | input | 1 | non-maskable request |
| irq_req_i | input | 1 | external request |
| irq_code_i | input | 12 | external request code |
| irl_i | input | 4 | encoded level, 0 = none |
| per_req_i | input | 1 | peripheral request |
| per_code_i | input | 12 | peripheral request code |
| mstp_we_i | input | 1 | module-stop write enable |
| mstp_wdata_i | input | 32 | module-stop write data |
| cpu_halt_o | output | 1 | core halt |
| status_o | output | 2 | state code pins |
| clk_out_en_o | output | 1 | clock output enable |
| int_accept_o | output | 1 | interrupt accept strobe |
| evt_code_o | output | 12 | event code |
| evt_code2_o | output | 12 | event code copy |
| mstp_rdata_o | output | 32 | module-stop readback |
| sp_clk_o | output | 2 | gated serial port clocks |

## Verification
The state, halt, status, accept strobe and event codes all change at the first rising edge after the stimulus. The bench drives inputs 2 ns after an edge and reads them 2 ns after the following edge. A module-stop write lands at the next edge, but the gate enable follows at the falling edge after it. The bench therefore waits two edges after a write before it counts gated clock edges. The interrupt sweep covers all fifteen request mixes in both states with both flag values. The expected codes are computed from the priority order.

// File: rtl/slp_pkg.sv
package slp_pkg;
  localparam int CODE_W = 12;
  typedef enum logic {ST_RUN = 1'b0, ST_SLEEP = 1'b1} slp_state_e;
endpackage

// File: rtl/slp_int_arb.sv
module slp_int_arb
  import slp_pkg::*;
#(
  parameter logic [CODE_W-1:0] NMI_CODE = 12'h1C0,
  parameter logic [CODE_W-1:0] IRL_BASE = 12'h200,
  parameter int                IRL_W    = 4
) (
  input  logic              nmi_i,
  input  logic              irq_req_i,
  input  logic [CODE_W-1:0] irq_code_i,
  input  logic [IRL_W-1:0]  irl_i,
  input  logic              per_req_i,
  input  logic [CODE_W-1:0] per_code_i,
  output logic              any_o,
  output logic [CODE_W-1:0] code_o
);
  localparam int PAD_W = CODE_W - IRL_W - 5;
  logic irl_req;
  logic [CODE_W-1:0] irl_code;

  assign irl_req  = |irl_i;
  assign irl_code = IRL_BASE + {{PAD_W{1'b0}}, irl_i, 5'b0};
  assign any_o    = nmi_i | irq_req_i | irl_req | per_req_i;

  // fixed priority: nmi > irq > irl > peripheral
  always_comb begin
    if (nmi_i)          code_o = NMI_CODE;
    else if (irq_req_i) code_o = irq_code_i;
    else if (irl_req)   code_o = irl_code;
    else                code_o = per_code_i;
  end
endmodule

// File: rtl/slp_fsm.sv
module slp_fsm
  import slp_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              man_rst_i,
  input  logic              sleep_i,
  input  logic              stby_sel_i,
  input  logic              bl_i,
  input  logic              any_req_i,
  input  logic [CODE_W-1:0] req_code_i,
  output slp_state_e        state_o,
  output logic              accept_o,
  output logic [CODE_W-1:0] evt_o,
  output logic [CODE_W-1:0] evt2_o
);
  slp_state_e state_q;
  logic take;

  // sleep ignores the block flag
  assign take = any_req_i & ((state_q == ST_SLEEP) | ~bl_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_RUN;
      accept_o <= 1'b0;
      evt_o    <= '0;
      evt2_o   <= '0;
    end else if (man_rst_i) begin
      state_q  <= ST_RUN;
      accept_o <= 1'b0;
    end else if (take) begin
      state_q  <= ST_RUN;
      accept_o <= 1'b1;
      evt_o    <= req_code_i;
      evt2_o   <= req_code_i;
    end else begin
      accept_o <= 1'b0;
      if (state_q == ST_RUN && sleep_i && !stby_sel_i) state_q <= ST_SLEEP;
    end
  end

  assign state_o = state_q;
endmodule

// File: rtl/slp_mstp.sv
module slp_mstp #(
  parameter int REG_W   = 32,
  parameter int NUM_SP  = 2,
  parameter int SP_BASE = 30
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             man_rst_i,
  input  logic             we_i,
  input  logic [REG_W-1:0] wdata_i,
  output logic [REG_W-1:0] rdata_o,
  output logic [NUM_SP-1:0] sp_clk_o
);
  logic [REG_W-1:0] mstp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        mstp_q <= '0;
    else if (man_rst_i) mstp_q <= '0;
    else if (we_i)      mstp_q <= wdata_i;
  end

  assign rdata_o = mstp_q;

  for (genvar k = 0; k < NUM_SP; k++) begin : g_gate
    logic en_q;
    // enable moves only while clk_i is low
    always_ff @(negedge clk_i or negedge rst_ni) begin
      if (!rst_ni) en_q <= 1'b1;
      else         en_q <= ~mstp_q[SP_BASE+k];
    end
    assign sp_clk_o[k] = clk_i & en_q;
  end
endmodule

// File: rtl/slp_ctrl_top.sv
module slp_ctrl_top
  import slp_pkg::*;
#(
  parameter logic [11:0] NMI_CODE = 12'h1C0,
  parameter logic [11:0] IRL_BASE = 12'h200,
  parameter int          IRL_W    = 4,
  parameter int          REG_W    = 32,
  parameter int          NUM_SP   = 2,
  parameter int          SP_BASE  = 30
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              man_rst_i,
  input  logic              sleep_i,
  input  logic              stby_sel_i,
  input  logic              bl_i,
  input  logic              nmi_i,
  input  logic              irq_req_i,
  input  logic [11:0]       irq_code_i,
  input  logic [IRL_W-1:0]  irl_i,
  input  logic              per_req_i,
  input  logic [11:0]       per_code_i,
  input  logic              mstp_we_i,
  input  logic [REG_W-1:0]  mstp_wdata_i,
  output logic              cpu_halt_o,
  output logic [1:0]        status_o,
  output logic              clk_out_en_o,
  output logic              int_accept_o,
  output logic [11:0]       evt_code_o,
  output logic [11:0]       evt_code2_o,
  output logic [REG_W-1:0]  mstp_rdata_o,
  output logic [NUM_SP-1:0] sp_clk_o
);
  logic any_req;
  logic [CODE_W-1:0] req_code;
  slp_state_e state;

  slp_int_arb #(.NMI_CODE(NMI_CODE), .IRL_BASE(IRL_BASE), .IRL_W(IRL_W)) u_arb (
    .nmi_i(nmi_i), .irq_req_i(irq_req_i), .irq_code_i(irq_code_i),
    .irl_i(irl_i), .per_req_i(per_req_i), .per_code_i(per_code_i),
    .any_o(any_req), .code_o(req_code)
  );

  slp_fsm u_fsm (
    .clk_i(clk_i), .rst_ni(rst_ni), .man_rst_i(man_rst_i),
    .sleep_i(sleep_i), .stby_sel_i(stby_sel_i), .bl_i(bl_i),
    .any_req_i(any_req), .req_code_i(req_code),
    .state_o(state), .accept_o(int_accept_o),
    .evt_o(evt_code_o), .evt2_o(evt_code2_o)
  );

  slp_mstp #(.REG_W(REG_W), .NUM_SP(NUM_SP), .SP_BASE(SP_BASE)) u_mstp (
    .clk_i(clk_i), .rst_ni(rst_ni), .man_rst_i(man_rst_i),
    .we_i(mstp_we_i), .wdata_i(mstp_wdata_i), .rdata_o(mstp_rdata_o),
    .sp_clk_o(sp_clk_o)
  );

  assign cpu_halt_o   = (state == ST_SLEEP);
  assign status_o     = (state == ST_SLEEP) ? 2'b10 : 2'b00;
  assign clk_out_en_o = (state == ST_SLEEP) || (state == ST_RUN);
endmodule

// File: rtl/slp_ctrl_chk.sv
module slp_ctrl_chk #(
  parameter logic [11:0] NMI_CODE = 12'h1C0,
  parameter int          REG_W    = 32
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             man_rst_i,
  input logic             sleep_i,
  input logic             stby_sel_i,
  input logic             bl_i,
  input logic             nmi_i,
  input logic             irq_req_i,
  input logic [3:0]       irl_i,
  input logic             per_req_i,
  input logic             cpu_halt_o,
  input logic [1:0]       status_o,
  input logic             clk_out_en_o,
  input logic             int_accept_o,
  input logic [11:0]      evt_code_o,
  input logic [REG_W-1:0] mstp_rdata_o
);
  logic any_req;
  assign any_req = nmi_i | irq_req_i | (|irl_i) | per_req_i;

  // R3
  sleep_status_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_halt_o |-> status_o == 2'b10 && clk_out_en_o);
  // R3
  run_status_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cpu_halt_o |-> status_o == 2'b00 && clk_out_en_o);
  // R1
  enter_sleep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cpu_halt_o && sleep_i && !stby_sel_i && !man_rst_i && !(any_req && !bl_i) |=> cpu_halt_o);
  // R2
  stby_stay_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cpu_halt_o && stby_sel_i && !any_req |=> !cpu_halt_o);
  // R4
  wake_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_halt_o && any_req && !man_rst_i |=> int_accept_o && !cpu_halt_o);
  // R5
  bl_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cpu_halt_o && bl_i |=> !int_accept_o);
  // R6
  nmi_code_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_halt_o && nmi_i && !man_rst_i |=> evt_code_o == NMI_CODE);
  // R6
  evt_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !int_accept_o |-> $stable(evt_code_o));
  // R9
  man_rst_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    man_rst_i |=> !cpu_halt_o && !int_accept_o && mstp_rdata_o == '0);
endmodule

bind slp_ctrl_top slp_ctrl_chk #(.NMI_CODE(NMI_CODE), .REG_W(REG_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .man_rst_i(man_rst_i), .sleep_i(sleep_i),
  .stby_sel_i(stby_sel_i), .bl_i(bl_i), .nmi_i(nmi_i), .irq_req_i(irq_req_i),
  .irl_i(irl_i), .per_req_i(per_req_i), .cpu_halt_o(cpu_halt_o),
  .status_o(status_o), .clk_out_en_o(clk_out_en_o), .int_accept_o(int_accept_o),
  .evt_code_o(evt_code_o), .mstp_rdata_o(mstp_rdata_o)
);

// File: tb/slp_ctrl_top_tb.sv
module slp_ctrl_top_tb;
  localparam logic [11:0] NMI_C = 12'h1C0;
  localparam logic [11:0] IRQ_C = 12'h5A0;
  localparam logic [11:0] PER_C = 12'h7E0;
  localparam logic [3:0]  IRL_V = 4'hA;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic man_rst_i = 0, sleep_i = 0, stby_sel_i = 0, bl_i = 0;
  logic nmi_i = 0, irq_req_i = 0, per_req_i = 0, mstp_we_i = 0;
  logic [11:0] irq_code_i = IRQ_C, per_code_i = PER_C;
  logic [3:0] irl_i = 0;
  logic [31:0] mstp_wdata_i = 0;
  logic cpu_halt_o, clk_out_en_o, int_accept_o;
  logic [1:0] status_o, sp_clk_o;
  logic [11:0] evt_code_o, evt_code2_o;
  logic [31:0] mstp_rdata_o;

  int n_run = 0, n_fail = 0;
  int cnt0 = 0, cnt1 = 0;
  bit done = 0;

  always #4 clk_i = ~clk_i;
  always @(posedge sp_clk_o[0]) cnt0++;
  always @(posedge sp_clk_o[1]) cnt1++;

  slp_ctrl_top u_dut (.*);

  task automatic tick();
    @(posedge clk_i); #2;
  endtask

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [11:0] exp_code(input logic [3:0] m);
    if (m[0]) return NMI_C;
    if (m[1]) return IRQ_C;
    if (m[2]) return 12'h200 + 12'(IRL_V) * 12'd32;
    return PER_C;
  endfunction

  task automatic drive_req(input logic [3:0] m);
    nmi_i = m[0]; irq_req_i = m[1]; irl_i = m[2] ? IRL_V : 4'h0; per_req_i = m[3];
  endtask

  task automatic go_sleep();
    sleep_i = 1; tick(); sleep_i = 0;
  endtask

  task automatic mstp_write(input logic [31:0] v);
    mstp_we_i = 1; mstp_wdata_i = v; tick(); mstp_we_i = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [11:0] prev;
    #5 rst_ni = 1; tick();
    // reset state
    chk(!cpu_halt_o && status_o == 2'b00, "R3 reset run", {30'b0, status_o}, 0);
    chk(clk_out_en_o, "R3 clk out run", clk_out_en_o, 1);
    chk(mstp_rdata_o == 0, "R7 reset mstp", mstp_rdata_o, 0);
    chk(evt_code_o == 0 && !int_accept_o, "R6 reset evt", evt_code_o, 0);

    // standby select blocks sleep
    stby_sel_i = 1; go_sleep(); stby_sel_i = 0;
    chk(!cpu_halt_o, "R2 standby", cpu_halt_o, 0);

    // sleep entry, held
    go_sleep();
    chk(cpu_halt_o && status_o == 2'b10, "R1 sleep entry", {30'b0, status_o}, 2);
    repeat (5) tick();
    chk(cpu_halt_o && status_o == 2'b10 && clk_out_en_o, "R1 sleep held / R3", {30'b0, status_o}, 2);

    // sweep of request mixes in sleep and run, both flag values
    for (int bl = 0; bl < 2; bl++) begin
      for (int m = 1; m < 16; m++) begin
        bl_i = bl[0];
        if (!cpu_halt_o) go_sleep();
        drive_req(4'(m)); tick(); drive_req(0);
        chk(int_accept_o && !cpu_halt_o, "R4 wake", {int_accept_o, cpu_halt_o}, 2);
        chk(evt_code_o == exp_code(4'(m)) && evt_code2_o == exp_code(4'(m)),
            "R6 code sleep / R5", evt_code_o, exp_code(4'(m)));
        tick();
        chk(!int_accept_o && status_o == 2'b00, "R4 single pulse", int_accept_o, 0);
        // run state acceptance depends on flag
        prev = evt_code_o;
        drive_req(4'(16 - m)); tick(); drive_req(0);
        chk(int_accept_o == !bl[0], "R5 run accept", int_accept_o, !bl[0]);
        chk(evt_code_o == (bl[0] ? prev : exp_code(4'(16 - m))), "R5 run code / R6",
            evt_code_o, bl[0] ? prev : exp_code(4'(16 - m)));
        tick();
      end
    end
    bl_i = 0;

    // accept beats sleep strobe
    sleep_i = 1; irq_req_i = 1; tick(); sleep_i = 0; irq_req_i = 0;
    chk(!cpu_halt_o && int_accept_o, "R10 accept wins", cpu_halt_o, 0);
    tick();

    // module stop register and gates
    mstp_write(32'h8000_1234);
    chk(mstp_rdata_o == 32'h8000_1234, "R7 readback", mstp_rdata_o, 32'h8000_1234);
    tick(); cnt0 = 0; cnt1 = 0; repeat (8) tick();
    chk(cnt1 == 0 && cnt0 == 8, "R8 bit31 run", cnt1, 0);
    mstp_write(32'h4000_0000); tick(); cnt0 = 0; cnt1 = 0;
    go_sleep(); repeat (7) tick();
    chk(cnt0 == 0 && cnt1 == 8, "R8 bit30 sleep", cnt0, 0);
    chk(cpu_halt_o, "R1 still asleep", cpu_halt_o, 1);

    // manual reset
    prev = evt_code_o;
    man_rst_i = 1; nmi_i = 1; tick(); man_rst_i = 0; nmi_i = 0;
    chk(!cpu_halt_o && !int_accept_o, "R9 man rst run", {cpu_halt_o, int_accept_o}, 0);
    chk(mstp_rdata_o == 0, "R9 mstp clr", mstp_rdata_o, 0);
    chk(evt_code_o == prev, "R9 evt kept", evt_code_o, prev);
    tick(); cnt0 = 0; cnt1 = 0; repeat (4) tick();
    chk(cnt0 == 4 && cnt1 == 4, "R9 clocks back", cnt0, 4);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule